// File: doc/BRIEF.md
# Operand Register Redirection Table

This block turns the register fields of an instruction into vector-aware operand descriptors. Software programs up to sixteen configuration slots. Each slot names a register class (integer or floating-point), a key register and a replacement base register, and carries an element-width code. From these slots the block keeps two expanded lookup tables, one per class, with one entry for each of the 32 architectural registers.

At issue, the destination and both source register numbers are presented together with the instruction's class. All three are looked up in parallel. For each operand the block reports whether it is a vector, which register the element loop should start from, and the element-width code. Two instruction-wide flags are added: one says that no operand is a vector, so the instruction can take the plain scalar path. The other says that a vector operand carries a reserved width code.

The lookup occupies its own pipeline stage. Results appear on the clock edge after the request.

Top module: `regvec_redirect`

## Requirements
- R1: After reset, every configuration slot is disabled and both tables are empty. `res_valid` is 0 and all result outputs are 0 until the first request.
- R2: A write with `cfg_we` high stores enable, class, key, base and width into slot `cfg_slot`. The tables are rebuilt on the next edge, so a lookup sampled on the second edge after the write edge sees the new contents, and a lookup sampled on the first edge still sees the old contents.
- R3: An operand whose register equals the key of an enabled slot of the instruction's class is reported as a vector. Its result register is the slot's base and its width is the slot's width code.
- R4: Any other operand is reported as scalar. Its register number passes through unchanged and its width code is 0 (default).
- R5: The integer table (`cfg_fp`/`lk_fp` = 0) and the floating-point table (= 1) are independent. A slot configures only its own class.
- R6: When several enabled slots have the same class and key, the slot with the highest index wins. Disabling that slot makes the next lower matching slot take effect, because the tables are rebuilt from a cleared state.
- R7: The three operands are looked up at the same time. Operand 0 is rd, 1 is rs1 and 2 is rs2. `res_vec[i]` is operand i. `res_reg[5i+4:5i]` and `res_width[3i+2:3i]` hold operand i's register and width.
- R8: `res_all_scalar` is 1 exactly when no operand of the request is a vector.
- R9: Width codes are 0 default, 1 for 8 bits, 2 for 16 bits, 3 for 32 bits and 4 for 64 bits. Codes 5 to 7 are reserved. `res_illegal` is 1 exactly when at least one vector operand carries a reserved code.
- R10: The results of a request sampled on an edge appear right after that edge, with `res_valid` high for that cycle only. When no request is sampled, `res_valid` is 0 and the other result outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration slot write strobe |
| cfg_slot | input | 4 | Slot index written |
| cfg_en | input | 1 | Slot enable |
| cfg_fp | input | 1 | Slot class: 0 integer, 1 floating-point |
| cfg_key | input | 5 | Register that becomes a vector |
| cfg_base | input | 5 | Starting register substituted for the key |
| cfg_width | input | 3 | Element-width code |
| lk_req | input | 1 | Lookup request |
| lk_fp | input | 1 | Instruction class for the lookup |
| lk_rd | input | 5 | Destination register number |
| lk_rs1 | input | 5 | First source register number |
| lk_rs2 | input | 5 | Second source register number |
| res_valid | output | 1 | Results belong to the request of the previous edge |
| res_vec | output | 3 | Per-operand vector flag |
| res_reg | output | 15 | Per-operand redirected register |
| res_width | output | 9 | Per-operand width code |
| res_all_scalar | output | 1 | No operand is a vector |
| res_illegal | output | 1 | A vector operand has a reserved width code |

## Verification
The hardest case to reach is a set of duplicate keys that are later partly disabled. It shows whether the rebuild really starts from a cleared table and whether the highest slot wins. The stimulus stacks two and then three slots on one key, disables them one at a time, and issues a lookup on every cycle around each write. This also covers the one-cycle window in which a lookup must still see the old table. A long random phase then draws keys and lookup registers from a small pool so that matches, collisions across classes and reserved widths occur often.

// File: rtl/regvec_pkg.sv
package regvec_pkg;

    localparam int RV_REG_W = 5;
    localparam int RV_WD_W  = 3;

    typedef enum logic [RV_WD_W-1:0] {
        WD_DEFAULT = 3'd0,
        WD_B8      = 3'd1,
        WD_B16     = 3'd2,
        WD_B32     = 3'd3,
        WD_B64     = 3'd4
    } wd_code_e;

    typedef struct packed {
        logic                en;
        logic                fp;
        logic [RV_REG_W-1:0] key;
        logic [RV_REG_W-1:0] base;
        logic [RV_WD_W-1:0]  wd;
    } cfg_slot_t;

    typedef struct packed {
        logic                vec;
        logic [RV_WD_W-1:0]  wd;
        logic [RV_REG_W-1:0] base;
    } tbl_slot_t;

    function automatic logic wd_reserved(input logic [RV_WD_W-1:0] code);
        return code > WD_B64;
    endfunction

endpackage

// File: rtl/regvec_cfg_store.sv
module regvec_cfg_store
    import regvec_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int ENT_W = $clog2(NUM_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ENT_W-1:0]                  wr_idx,
    input  cfg_slot_t                         wr_data,
    output cfg_slot_t [NUM_ENTRIES-1:0]       slots_q
);

    cfg_slot_t [NUM_ENTRIES-1:0] slots_d;

    always_comb begin
        slots_d = slots_q;
        if (wr_en) begin
            slots_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slots_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/regvec_table_build.sv
module regvec_table_build
    import regvec_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_REGS    = 32,
    localparam int NUM_CLASSES = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  cfg_slot_t [NUM_ENTRIES-1:0]                   slots,
    output tbl_slot_t [NUM_CLASSES-1:0][NUM_REGS-1:0]     tbl_q
);

    tbl_slot_t [NUM_CLASSES-1:0][NUM_REGS-1:0] tbl_d;

    // Rebuild from a cleared table; later slots overwrite earlier ones.
    always_comb begin
        tbl_d = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (slots[i].en) begin
                tbl_d[slots[i].fp][slots[i].key].vec  = 1'b1;
                tbl_d[slots[i].fp][slots[i].key].wd   = slots[i].wd;
                tbl_d[slots[i].fp][slots[i].key].base = slots[i].base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
            assert_empty_slot_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !tbl_q[c][0].vec |-> (tbl_q[c][0].wd == '0 && tbl_q[c][0].base == '0));
        end
    endgenerate

endmodule

// File: rtl/regvec_lookup.sv
module regvec_lookup
    import regvec_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  tbl_slot_t [NUM_REGS-1:0] row,
    input  logic [REG_W-1:0]         reg_in,
    output logic                     is_vec,
    output logic [REG_W-1:0]         reg_out,
    output logic [RV_WD_W-1:0]       wd_out,
    output logic                     bad_wd
);

    tbl_slot_t hit;

    always_comb begin
        hit     = row[reg_in];
        is_vec  = hit.vec;
        reg_out = hit.vec ? hit.base : reg_in;
        wd_out  = hit.vec ? hit.wd : WD_DEFAULT;
        bad_wd  = hit.vec && wd_reserved(hit.wd);
    end

endmodule

// File: rtl/regvec_redirect.sv
module regvec_redirect
    import regvec_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_REGS    = 32,
    localparam int ENT_W  = $clog2(NUM_ENTRIES),
    localparam int REG_W  = $clog2(NUM_REGS),
    localparam int NUM_OP = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ENT_W-1:0]          cfg_slot,
    input  logic                      cfg_en,
    input  logic                      cfg_fp,
    input  logic [REG_W-1:0]          cfg_key,
    input  logic [REG_W-1:0]          cfg_base,
    input  logic [RV_WD_W-1:0]        cfg_width,
    input  logic                      lk_req,
    input  logic                      lk_fp,
    input  logic [REG_W-1:0]          lk_rd,
    input  logic [REG_W-1:0]          lk_rs1,
    input  logic [REG_W-1:0]          lk_rs2,
    output logic                      res_valid,
    output logic [NUM_OP-1:0]         res_vec,
    output logic [NUM_OP*REG_W-1:0]   res_reg,
    output logic [NUM_OP*RV_WD_W-1:0] res_width,
    output logic                      res_all_scalar,
    output logic                      res_illegal
);

    typedef struct packed {
        logic                      valid;
        logic [NUM_OP-1:0]         vec;
        logic [NUM_OP*REG_W-1:0]   regs;
        logic [NUM_OP*RV_WD_W-1:0] wd;
        logic                      all_scalar;
        logic                      illegal;
    } res_t;

    cfg_slot_t                     wr_data;
    cfg_slot_t [NUM_ENTRIES-1:0]   slots;
    tbl_slot_t [1:0][NUM_REGS-1:0] tbl;
    tbl_slot_t [NUM_REGS-1:0]      row;
    logic [NUM_OP*REG_W-1:0]       op_in;
    logic [NUM_OP-1:0]             op_vec;
    logic [NUM_OP*REG_W-1:0]       op_reg;
    logic [NUM_OP*RV_WD_W-1:0]     op_wd;
    logic [NUM_OP-1:0]             op_bad;
    res_t                          res_d, res_q;

    always_comb begin
        wr_data.en   = cfg_en;
        wr_data.fp   = cfg_fp;
        wr_data.key  = cfg_key;
        wr_data.base = cfg_base;
        wr_data.wd   = cfg_width;
    end

    regvec_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_slot),
        .wr_data(wr_data),
        .slots_q(slots)
    );

    regvec_table_build #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_REGS(NUM_REGS)) u_build (
        .clk  (clk),
        .rst_n(rst_n),
        .slots(slots),
        .tbl_q(tbl)
    );

    assign row   = tbl[lk_fp];
    assign op_in = {lk_rs2, lk_rs1, lk_rd};

    generate
        for (genvar g = 0; g < NUM_OP; g++) begin : g_op
            regvec_lookup #(.NUM_REGS(NUM_REGS)) u_lk (
                .row    (row),
                .reg_in (op_in[g*REG_W +: REG_W]),
                .is_vec (op_vec[g]),
                .reg_out(op_reg[g*REG_W +: REG_W]),
                .wd_out (op_wd[g*RV_WD_W +: RV_WD_W]),
                .bad_wd (op_bad[g])
            );

            assert_scalar_default_wd_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && !res_vec[g]) |-> res_width[g*RV_WD_W +: RV_WD_W] == '0);
        end
    endgenerate

    always_comb begin
        res_d       = res_q;
        res_d.valid = lk_req;
        if (lk_req) begin
            res_d.vec        = op_vec;
            res_d.regs       = op_reg;
            res_d.wd         = op_wd;
            res_d.all_scalar = ~|op_vec;
            res_d.illegal    = |op_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid      = res_q.valid;
    assign res_vec        = res_q.vec;
    assign res_reg        = res_q.regs;
    assign res_width      = res_q.wd;
    assign res_all_scalar = res_q.all_scalar;
    assign res_illegal    = res_q.illegal;

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!res_valid && $stable(res_reg)));

    assert_rd_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (res_vec[0] || res_reg[REG_W-1:0] == $past(lk_rd)));

    assert_all_scalar_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!res_all_scalar || res_reg == {$past(lk_rs2), $past(lk_rs1), $past(lk_rd)}));

    assert_illegal_needs_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> res_vec != '0);

endmodule

// File: tb/regvec_redirect_bench.sv
module regvec_redirect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_slot = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_fp = 1'b0;
    logic [4:0]  cfg_key = '0;
    logic [4:0]  cfg_base = '0;
    logic [2:0]  cfg_width = '0;
    logic        lk_req = 1'b0;
    logic        lk_fp = 1'b0;
    logic [4:0]  lk_rd = '0;
    logic [4:0]  lk_rs1 = '0;
    logic [4:0]  lk_rs2 = '0;
    logic        res_valid;
    logic [2:0]  res_vec;
    logic [14:0] res_reg;
    logic [8:0]  res_width;
    logic        res_all_scalar;
    logic        res_illegal;

    regvec_redirect u_regvec_redirect (.*);

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string tag = "R1";

    // reference state
    int m_en[16], m_fp[16], m_key[16], m_base[16], m_wd[16];
    int t_vec[2][32], t_base[2][32], t_wd[2][32];
    int e_valid = 0, e_vec = 0, e_reg = 0, e_wd = 0, e_all = 0, e_ill = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic rebuild();
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 32; r++) begin
                int found = -1;
                for (int s = 15; s >= 0 && found < 0; s--)
                    if (m_en[s] != 0 && m_fp[s] == c && m_key[s] == r) found = s;
                t_vec[c][r]  = (found >= 0) ? 1 : 0;
                t_base[c][r] = (found >= 0) ? m_base[found] : 0;
                t_wd[c][r]   = (found >= 0) ? m_wd[found] : 0;
            end
    endtask

    task automatic model_edge();
        e_valid = lk_req;
        if (lk_req) begin
            int ops[3];
            int c;
            ops[0] = lk_rd; ops[1] = lk_rs1; ops[2] = lk_rs2;
            c = lk_fp;
            e_vec = 0; e_reg = 0; e_wd = 0; e_ill = 0;
            for (int i = 0; i < 3; i++) begin
                if (t_vec[c][ops[i]] != 0) begin
                    e_vec |= (1 << i);
                    e_reg |= t_base[c][ops[i]] << (5 * i);
                    e_wd  |= t_wd[c][ops[i]] << (3 * i);
                    if (t_wd[c][ops[i]] >= 5) e_ill = 1;
                end else begin
                    e_reg |= ops[i] << (5 * i);
                end
            end
            e_all = (e_vec == 0) ? 1 : 0;
        end
        rebuild();
        if (cfg_we) begin
            m_en[cfg_slot] = cfg_en; m_fp[cfg_slot] = cfg_fp; m_key[cfg_slot] = cfg_key;
            m_base[cfg_slot] = cfg_base; m_wd[cfg_slot] = cfg_width;
        end
    endtask

    task automatic compare();
        chk(tag, "res_valid", res_valid, e_valid);
        chk(tag, "res_vec", res_vec, e_vec);
        chk(tag, "res_reg", res_reg, e_reg);
        chk(tag, "res_width", res_width, e_wd);
        chk(tag, "res_all_scalar", res_all_scalar, e_all);
        chk(tag, "res_illegal", res_illegal, e_ill);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cfg_we = 1'b0;
        lk_req = 1'b0;
    endtask

    task automatic wr(input int slot, input int en, input int fp, input int key, input int base, input int wd);
        cfg_we = 1'b1; cfg_slot = 4'(slot); cfg_en = 1'(en); cfg_fp = 1'(fp);
        cfg_key = 5'(key); cfg_base = 5'(base); cfg_width = 3'(wd);
    endtask

    task automatic lk(input int fp, input int rd, input int rs1, input int rs2);
        lk_req = 1'b1; lk_fp = 1'(fp); lk_rd = 5'(rd); lk_rs1 = 5'(rs1); lk_rs2 = 5'(rs2);
    endtask

    // write then look up on each of the following three cycles
    task automatic wr_probe(input int slot, input int en, input int fp, input int key,
                            input int base, input int wd, input int rs1, input int rs2);
        wr(slot, en, fp, key, base, wd);
        lk(fp, key, rs1, rs2);
        tick();
        for (int k = 0; k < 3; k++) begin
            lk(fp, key, rs1, rs2);
            tick();
        end
    endtask

    initial begin
        for (int s = 0; s < 16; s++) begin
            m_en[s] = 0; m_fp[s] = 0; m_key[s] = 0; m_base[s] = 0; m_wd[s] = 0;
        end
        rebuild();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, empty tables
        tag = "R1";
        compare();
        lk(0, 3, 7, 31); tick();
        lk(1, 0, 15, 9); tick();

        // R2 and R3: integer slot, lookup timing around the write
        tag = "R2";
        wr_probe(0, 1, 0, 3, 10, 2, 4, 5);
        tag = "R3";
        lk(0, 4, 3, 3); tick();

        // R5: floating-point slot on the same key
        tag = "R5";
        wr_probe(1, 1, 1, 3, 20, 4, 3, 6);
        lk(0, 3, 3, 3); tick();
        lk(1, 3, 3, 3); tick();

        // R6: duplicate keys, higher slot wins, disabling reveals lower
        tag = "R6";
        wr_probe(5, 1, 0, 7, 11, 1, 0, 7);
        wr_probe(9, 1, 0, 7, 22, 3, 7, 0);
        wr_probe(12, 1, 0, 7, 29, 4, 7, 7);
        wr_probe(12, 0, 0, 7, 29, 4, 7, 7);
        wr_probe(9, 0, 0, 7, 22, 3, 7, 7);
        wr_probe(5, 0, 0, 7, 11, 1, 7, 7);

        // R9: reserved widths
        tag = "R9";
        wr_probe(2, 1, 0, 12, 13, 6, 1, 2);
        wr_probe(3, 1, 0, 14, 15, 5, 14, 1);
        wr_probe(4, 1, 1, 12, 16, 7, 12, 12);
        lk(0, 1, 2, 14); tick();

        // R7 and R8: operand positions and all-scalar flag
        tag = "R7";
        lk(0, 3, 12, 14); tick();
        lk(0, 14, 3, 8); tick();
        tag = "R8";
        lk(0, 1, 2, 8); tick();
        lk(1, 1, 2, 14); tick();

        // R10: holding without requests
        tag = "R10";
        lk(0, 3, 14, 12); tick();
        repeat (3) tick();
        wr(0, 0, 0, 3, 0, 0); tick();
        tick();
        lk(0, 3, 3, 3); tick();

        // R7: random traffic over a small register pool
        tag = "R7";
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0)
                wr($urandom_range(0, 15), $urandom_range(0, 3) != 0, $urandom_range(0, 1),
                   $urandom_range(0, 5), $urandom_range(0, 31), $urandom_range(0, 7));
            if ($urandom_range(0, 3) != 0)
                lk($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 5),
                   $urandom_range(0, 5));
            tick();
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule